// File: doc/BRIEF.md
# Four-Source Daisy-Chained Vectored Interrupt Controller

This block is the interrupt side of a four-channel peripheral that sits in a system-wide priority chain. Each of its four sources raises a one-cycle request pulse; if that source has been enabled by a control word, the request is latched as pending. The block asks the processor for service through an active-low request output. When the processor runs an acknowledge cycle and the upstream chain input grants priority, it drives an 8-bit vector. The vector combines a software-written base with the number of the winning source.

After a vector has been delivered, that source is held in service and the chain output to lower-priority devices stays low. A higher-priority source may still nest over it. The in-service source is released when the block sees the two-byte return-from-interrupt opcode pair fetched on the data bus. Bus cycles are decoded from the usual active-low strobes: chip enable, I/O request, read and opcode-fetch (M1). All of them are sampled on the rising clock edge.

Top module: `intc_daisy4`

## Requirements
- R1: After synchronous reset, int_n is 1, dout_en is 0, all sources are disabled and nothing is pending or in service, so ieo equals iei.
- R2: A write (ce_n=0, iorq_n=0, rd_n=1, m1_n=1) to sel=0 with din[0]=0 stores din[7:3] as the vector base; din[2:1] are ignored. The delivered vector is {base, source number in bits 2:1, 0}.
- R3: A write with din[0]=1 is a control word for source sel: din[7] sets (1) or clears (0) its enable. If din[2]=1, the next write to that same sel is a time-constant word and changes neither enable nor base.
- R4: A request pulse on an enabled source makes it pending and drives int_n low. A pulse on a disabled source has no effect.
- R5: When several sources are eligible, the lowest-numbered one (source 0 highest) supplies the vector.
- R6: The vector is driven (dout_en=1) only during an acknowledge (m1_n=0, iorq_n=0, rd_n=1) while iei=1 and a source is eligible. An acknowledge seen with iei=0 leaves the request pending.
- R7: At the end of an acknowledge that drove a vector, the winner's pending flag clears and its in-service flag sets.
- R8: Request pulses that arrive while m1_n is low do not change pending state or the winner until m1_n rises; they are then taken up.
- R9: A source is blocked from requesting while it or any higher-priority source is in service; a higher-priority source still raises int_n.
- R10: Opcode fetches (m1_n=0, rd_n=0, iorq_n=1) of 0xED and then 0x4D on the next fetch release the highest-priority in-service source, but only when iei=1. An 0xED followed by any other byte is discarded.
- R11: ieo is 1 only when iei is 1, no source is in service and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge cycle marker, active low |
| sel | input | 2 | Source (channel) select for writes |
| din | input | 8 | Data bus as seen by the block |
| req | input | 4 | One-cycle request pulses, one per source |
| iei | input | 1 | Chain enable in, high grants priority |
| dout | output | 8 | Vector, zero when not driven |
| dout_en | output | 1 | High while the vector is driven |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable out |

## Verification
Single requests on each source check the vector encoding and the base field. Simultaneous requests check the priority order. Nested sequences (a low source in service, then a higher and a lower one arriving) separate true blocking from plain priority. Acknowledges with the chain input low, requests injected while M1 is low, and return sequences with a stray byte between the two opcodes, or with the chain input low, each test one gating condition that a wrong design would ignore.

// File: rtl/intc_pkg.sv
// Shared types and constants for the daisy-chained interrupt controller.
// Assumes the bus strobes have already been sampled in the clock domain.
package intc_pkg;
    localparam logic [7:0] OP_PREFIX = 8'hED;
    localparam logic [7:0] OP_RETURN = 8'h4D;

    typedef struct packed {
        logic wr_stb;     // first cycle of an I/O write
        logic ack_now;    // acknowledge cycle active
        logic ack_end;    // acknowledge just ended
        logic fetch_stb;  // first cycle of an opcode fetch
        logic m1_low;     // M1 asserted (request status frozen)
    } bus_strb_t;
endpackage

// File: rtl/intc_bus_decode.sv
// Decodes the processor strobes into one-cycle events.
// Assumes strobes are synchronous to clk; each event fires once per bus cycle.
module intc_bus_decode
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      iorq_n,
    input  logic      rd_n,
    input  logic      m1_n,
    output bus_strb_t strb
);
    logic wr_now, fetch_now, ack_now;
    logic wr_q, fetch_q, ack_q;

    // Classify the current bus cycle.
    always_comb begin
        wr_now    = !ce_n && !iorq_n && rd_n && m1_n;
        ack_now   = !m1_n && !iorq_n && rd_n;
        fetch_now = !m1_n && !rd_n && iorq_n;
    end

    // Remember last cycle's classification for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            fetch_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            wr_q    <= wr_now;
            fetch_q <= fetch_now;
            ack_q   <= ack_now;
        end
    end

    // Form the event strobes.
    always_comb begin
        strb.wr_stb    = wr_now && !wr_q;
        strb.ack_now   = ack_now;
        strb.ack_end   = ack_q && !ack_now;
        strb.fetch_stb = fetch_now && !fetch_q;
        strb.m1_low    = !m1_n;
    end
endmodule

// File: rtl/intc_cfg.sv
// Holds the vector base and per-source enables written by software.
// Assumes a control word has bit 0 set; bit 2 marks a following time constant
// that this block swallows without effect.
module intc_cfg
    import intc_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int VEC_W  = 8,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int BASE_W = VEC_W - SRC_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_strb_t         strb,
    input  logic [SRC_W-1:0]  sel,
    input  logic [VEC_W-1:0]  din,
    output logic [BASE_W-1:0] base,
    output logic [N_SRC-1:0]  en
);
    logic [N_SRC-1:0] tc_next;

    // Decode writes into base, enable and time-constant-pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            en      <= '0;
            tc_next <= '0;
        end else if (strb.wr_stb) begin
            if (tc_next[sel]) begin
                tc_next[sel] <= 1'b0;
            end else if (din[0]) begin
                en[sel]      <= din[VEC_W-1];
                tc_next[sel] <= din[2];
            end else if (sel == '0) begin
                base <= din[VEC_W-1:SRC_W+1];
            end
        end
    end

    // A swallowed time constant leaves the configuration untouched.
    p_tc_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.wr_stb && tc_next[sel]) |=> ($stable(en) && $stable(base)));
endmodule

// File: rtl/intc_prio.sv
// Pending, deferred and in-service state with the fixed-priority winner.
// Assumes source 0 is highest priority and that releases arrive from the
// opcode snooper as one-cycle strobes.
module intc_prio
    import intc_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int SRC_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_strb_t        strb,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic             iei,
    input  logic             rel_stb,
    output logic             win_valid,
    output logic [SRC_W-1:0] win_idx,
    output logic             svc_any,
    output logic             pend_any
);
    logic [N_SRC-1:0] pending, held, in_svc;
    logic [N_SRC-1:0] blocked, elig, rel_mask, clr_mask, set_now;
    logic             served;
    logic [SRC_W-1:0] srv_idx;

    // Block each source at or below any in-service source.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            acc        = acc | in_svc[i];
            blocked[i] = acc;
        end
        elig = pending & ~blocked;
    end

    // Pick the lowest-numbered eligible source.
    always_comb begin
        win_valid = |elig;
        win_idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = SRC_W'(i);
        end
    end

    // Mask of the highest-priority in-service source, for release.
    always_comb begin
        logic found;
        found    = 1'b0;
        rel_mask = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (in_svc[i] && !found) begin
                rel_mask[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // Completed acknowledge and newly accepted requests.
    always_comb begin
        clr_mask = '0;
        if (strb.ack_end && served) clr_mask[srv_idx] = 1'b1;
        set_now = req & en;
    end

    // Remember whether, and for whom, the current acknowledge drove a vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served  <= 1'b0;
            srv_idx <= '0;
        end else if (strb.ack_now) begin
            if (!served && iei && win_valid) begin
                served  <= 1'b1;
                srv_idx <= win_idx;
            end
        end else begin
            served <= 1'b0;
        end
    end

    // Update pending, deferred and in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            held    <= '0;
            in_svc  <= '0;
        end else begin
            if (strb.m1_low) begin
                held    <= (held | set_now) & en;
                pending <= pending & ~clr_mask & en;
            end else begin
                held    <= '0;
                pending <= ((pending & ~clr_mask) | held | set_now) & en;
            end
            in_svc <= (in_svc & ~(rel_stb ? rel_mask : '0)) | clr_mask;
        end
    end

    always_comb begin
        svc_any  = |in_svc;
        pend_any = |pending;
    end

    // Frozen request status while M1 is low.
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strb.m1_low |=> ((pending & ~$past(pending)) == '0));
    // Delivered vector puts its source in service.
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.ack_end && served) |=> in_svc[$past(srv_idx)]);
    // A release drops exactly one in-service source.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_stb && (in_svc != '0)) |=>
            ($countones(in_svc) == $countones($past(in_svc)) - 1));
endmodule

// File: rtl/intc_reti_snoop.sv
// Watches opcode fetches for the two-byte return sequence.
// Assumes the prefix byte must be followed by the second byte on the very
// next fetch; any other byte discards it.
module intc_reti_snoop
    import intc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_strb_t        strb,
    input  logic [VEC_W-1:0] din,
    input  logic             iei,
    output logic             rel_stb
);
    logic saw_prefix;

    // Track whether the previous fetch was the prefix byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saw_prefix <= 1'b0;
        end else if (strb.fetch_stb) begin
            saw_prefix <= (din == OP_PREFIX);
        end
    end

    // Release only on prefix then return byte, with chain priority held.
    always_comb begin
        rel_stb = strb.fetch_stb && saw_prefix && (din == OP_RETURN) && iei;
    end
endmodule

// File: rtl/intc_daisy4.sv
// Top of the daisy-chained vectored interrupt controller.
// Assumes synchronous strobes and a push-pull vector output with an enable.
module intc_daisy4
    import intc_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int BASE_W = VEC_W - SRC_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             iorq_n,
    input  logic             rd_n,
    input  logic             m1_n,
    input  logic [SRC_W-1:0] sel,
    input  logic [VEC_W-1:0] din,
    input  logic [N_SRC-1:0] req,
    input  logic             iei,
    output logic [VEC_W-1:0] dout,
    output logic             dout_en,
    output logic             int_n,
    output logic             ieo
);
    bus_strb_t         strb;
    logic [BASE_W-1:0] base;
    logic [N_SRC-1:0]  en;
    logic              rel_stb, win_valid, svc_any, pend_any;
    logic [SRC_W-1:0]  win_idx;

    intc_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .m1_n(m1_n), .strb(strb)
    );

    intc_cfg #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .strb(strb), .sel(sel), .din(din),
        .base(base), .en(en)
    );

    intc_reti_snoop #(.VEC_W(VEC_W)) u_snoop (
        .clk(clk), .rst_n(rst_n), .strb(strb), .din(din), .iei(iei),
        .rel_stb(rel_stb)
    );

    intc_prio #(.N_SRC(N_SRC)) u_prio (
        .clk(clk), .rst_n(rst_n), .strb(strb), .req(req), .en(en),
        .iei(iei), .rel_stb(rel_stb), .win_valid(win_valid),
        .win_idx(win_idx), .svc_any(svc_any), .pend_any(pend_any)
    );

    // Drive the vector and the chain/request outputs.
    always_comb begin
        dout_en = strb.ack_now && iei && win_valid;
        dout    = dout_en ? {base, win_idx, 1'b0} : '0;
        int_n   = !win_valid;
        ieo     = iei && !svc_any && !pend_any;
    end

    // Vector only appears inside a granted acknowledge.
    p_vec_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!m1_n && !iorq_n && rd_n && iei));
    // Chain output never rises without the chain input.
    p_ieo_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !ieo);
    // A request output needs pending state behind it.
    p_int_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> pend_any);
    // Vector bit 0 is always zero.
    p_vec_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !dout[0]);
endmodule

// File: tb/intc_daisy4_tb_top.sv
module intc_daisy4_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic [1:0] sel = '0;
    logic [7:0] din = '0;
    logic [3:0] req = '0;
    logic       iei = 1'b1;
    logic [7:0] dout;
    logic       dout_en, int_n, ieo;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       sample_now = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_daisy4 dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .sel(sel), .din(din), .req(req), .iei(iei),
        .dout(dout), .dout_en(dout_en), .int_n(int_n), .ieo(ieo)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic status(input string tag, input logic e_int_n, input logic e_ieo);
        @(negedge clk);
        check({tag, " int_n"}, {8'h0, int_n}, {8'h0, e_int_n});
        check({tag, " ieo"}, {8'h0, ieo}, {8'h0, e_ieo});
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        sel = s; din = d; ce_n = 1'b0; iorq_n = 1'b0;
        @(posedge clk); #1;
        ce_n = 1'b1; iorq_n = 1'b1;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(posedge clk); #1; req = m;
        @(posedge clk); #1; req = '0;
    endtask

    // Driver: runs an acknowledge and pushes the expected {dout_en, dout}.
    task automatic ack(input string tag, input logic [8:0] exp, input logic [3:0] inj);
        @(posedge clk); #1; m1_n = 1'b0; req = inj;
        @(posedge clk); #1; req = '0; iorq_n = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(tag); sample_now = 1'b1;
        @(posedge clk); #1; sample_now = 1'b0;
        @(posedge clk); #1; m1_n = 1'b1; iorq_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic fetch(input logic [7:0] op);
        @(posedge clk); #1; m1_n = 1'b0; rd_n = 1'b0; din = op;
        @(posedge clk); #1; m1_n = 1'b1; rd_n = 1'b1;
    endtask

    // Monitor: pops expected vectors and compares against the bus.
    always @(negedge clk) begin
        if (sample_now && exp_q.size() > 0) begin
            check(tag_q.pop_front(), {dout_en, dout}, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 int_n", {8'h0, int_n}, 9'h1);
        check("R1 dout_en", {8'h0, dout_en}, 9'h0);
        check("R1 ieo", {8'h0, ieo}, 9'h1);
        iei = 1'b0;
        @(negedge clk);
        check("R1 ieo follows iei", {8'h0, ieo}, 9'h0);
        iei = 1'b1;

        // R2 base with bits 2:1 set that must be ignored
        bus_write(2'd0, 8'hAE);
        // R4 disabled source ignored
        pulse(4'b1000);
        status("R4 disabled", 1'b1, 1'b1);
        // R3 enables; source 2 announces a time constant of 0x01
        bus_write(2'd0, 8'h81);
        bus_write(2'd1, 8'h81);
        bus_write(2'd3, 8'h81);
        bus_write(2'd2, 8'h85);
        bus_write(2'd2, 8'h01);
        pulse(4'b0100);
        status("R3 tc swallowed", 1'b0, 1'b0);
        ack("R3 R2 src2 vector", 9'h1AC, '0);
        status("R7 src2 in service", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R10 released", 1'b1, 1'b1);

        // R4/R2 single request on source 1
        pulse(4'b0010);
        status("R4 pending", 1'b0, 1'b0);
        ack("R2 src1 vector", 9'h1AA, '0);
        status("R7 after ack", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R10 release src1", 1'b1, 1'b1);

        // R5 simultaneous, R9 blocking of lower
        pulse(4'b0110);
        ack("R5 src1 wins", 9'h1AA, '0);
        status("R9 src2 blocked", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R9 src2 unblocked", 1'b0, 1'b0);
        ack("R5 src2 next", 9'h1AC, '0);
        fetch(8'hED); fetch(8'h4D);
        status("R11 idle", 1'b1, 1'b1);

        // R9 nesting
        pulse(4'b0100);
        ack("R9 src2", 9'h1AC, '0);
        pulse(4'b0001);
        status("R9 higher nests", 1'b0, 1'b0);
        ack("R9 src0 vector", 9'h1A8, '0);
        pulse(4'b1000);
        status("R9 lower blocked", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R10 src0 released first", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R10 src2 released", 1'b0, 1'b0);
        ack("R5 src3 vector", 9'h1AE, '0);
        fetch(8'hED); fetch(8'h4D);
        status("R11 idle again", 1'b1, 1'b1);

        // R6 acknowledge with iei low
        pulse(4'b0010);
        iei = 1'b0;
        ack("R6 no vector", 9'h000, '0);
        status("R6 still pending", 1'b0, 1'b0);
        iei = 1'b1;
        ack("R6 vector granted", 9'h1AA, '0);

        // R10 return with iei low does nothing
        iei = 1'b0;
        fetch(8'hED); fetch(8'h4D);
        iei = 1'b1;
        status("R10 iei low no release", 1'b1, 1'b0);
        // R10 stray byte between prefix and return
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        status("R10 stray discarded", 1'b1, 1'b0);
        fetch(8'hED); fetch(8'h4D);
        status("R10 clean release", 1'b1, 1'b1);

        // R8 request injected while M1 low
        pulse(4'b0010);
        ack("R8 winner unchanged", 9'h1AA, 4'b0001);
        status("R8 deferred taken up", 1'b0, 1'b0);
        ack("R8 src0 after", 9'h1A8, '0);
        fetch(8'hED); fetch(8'h4D);
        fetch(8'hED); fetch(8'h4D);
        status("R11 final", 1'b1, 1'b1);

        // R3 disable via control word
        bus_write(2'd1, 8'h01);
        pulse(4'b0010);
        status("R3 disabled source", 1'b1, 1'b1);

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule